// File: doc/BRIEF.md
# SAR Converter Serial Output Sequencer

This block is the digital half of a single-channel successive-approximation converter read through a three-wire serial port. A host lowers an active-low chip select and toggles a serial clock. The block opens a sample window and then steps a trial code through a DAC one bit per serial clock. It keeps or drops each trial bit according to a one-bit comparator answer. It shifts the result onto a serial data line together with an enable for the line's output driver.

On every serial falling edge the line presents one item of a fixed stream. First come two framing bits, then the result with the most significant bit first. Next comes the result again with the least significant bit first, starting from bit 1 so that bit 0 is not sent twice. Zeros follow for as long as clocks keep coming. The serial pins are sampled by a faster core clock. The sample-and-hold, comparator and DAC are analog parts outside this block.

Top module: `sar_serial_seq`

## Requirements
- R1: While reset is asserted and directly after it is released, `sdo_oe`, `smp_track`, `sdo` and `dac_code` are all 0.
- R2: If `cs_n` is low when reset is released, serial clocks have no effect (`sdo_oe` and `smp_track` stay 0, `dac_code` stays 0) until `cs_n` has been high and then goes low again.
- R3: `sdo_oe` goes to 1 on the first falling `sclk` edge after `cs_n` falls. It is 0 at most two core cycles after `cs_n` is high. Raising `cs_n` ends a conversion at any point, and the next conversion starts from the beginning.
- R4: `smp_track` goes to 1 on the first rising `sclk` edge after `cs_n` falls. It returns to 0 on the second counted falling edge.
- R5: On the second counted falling edge, `sdo` is 0 (the null bit).
- R6: Each trial sets the bit under test to 1 in `dac_code`. The bit is kept when `comp_ge` is 1 (input at or above the DAC level) and cleared otherwise. After the last trial, `dac_code` holds the straight-binary result, from 000h up to FFFh, with over-range inputs giving FFFh.
- R7: Counted falling edges 3 to 14 present result bits B11 down to B0 on `sdo`.
- R8: Counted falling edges 15 to 25 present B1 up to B11 on `sdo`; B0 is not repeated.
- R9: Every counted falling edge after the 25th presents 0 on `sdo`.
- R10: `sdo` changes only after a falling `sclk` edge, or when `cs_n` rises; it is stable across rising edges.
- R11: When `sclk` idles high, a falling edge before the first rising edge enables the output but is not counted.
- R12: A serial falling edge is reflected on `sdo` exactly `SYNC_STAGES`+1 core clock cycles later (two with the default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| comp_ge | input | 1 | Comparator: 1 when held input is at or above the DAC level |
| dac_code | output | CODE_W | Trial code driving the DAC |
| sdo | output | 1 | Serial data line value |
| sdo_oe | output | 1 | Output enable for the serial data driver |
| smp_track | output | 1 | Sample switch closed (tracking the input) |

## Verification
The bit decision and its appearance on the data line happen on the same falling-edge event. The comparator answer for the current trial is stored into the result and driven onto `sdo` at once, while the DAC code moves on to the next trial. The bench's comparator model reads `dac_code` live. It changes the live analog value right after the sample window closes, so any use of a stale trial or of an unheld input shows up as a wrong bit. Each bit is judged against the expected code, both on the line and in the final `dac_code`. The other collision is the closing of the sample window with the null bit and the loading of the first trial, which is judged on the second edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SESS_LOCK = 2'd0,
    SESS_IDLE = 2'd1,
    SESS_RUN  = 2'd2
  } sess_e;

  typedef enum logic [1:0] {
    PH_PRE  = 2'd0,
    PH_MSB  = 2'd1,
    PH_LSB  = 2'd2,
    PH_ZERO = 2'd3
  } phase_e;

endpackage

// File: rtl/sar_seq_edge.sv
// Samples the serial pins into the core clock domain and finds sclk edges.
module sar_seq_edge #(
  parameter int SYNC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic cs_hi,
  output logic sclk_rise,
  output logic sclk_fall
);

  logic [SYNC-1:0] cs_st;
  logic [SYNC:0]   ck_st;

  // cs stages reset to 0 so that a low select at reset looks low (locked)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_st <= '0;
      ck_st <= '0;
    end else begin
      cs_st[0] <= cs_n;
      ck_st[0] <= sclk;
      for (int i = 1; i < SYNC; i++) cs_st[i] <= cs_st[i-1];
      for (int i = 1; i <= SYNC; i++) ck_st[i] <= ck_st[i-1];
    end
  end

  assign cs_hi     = cs_st[SYNC-1];
  assign sclk_rise =  ck_st[SYNC-1] & ~ck_st[SYNC];
  assign sclk_fall = ~ck_st[SYNC-1] &  ck_st[SYNC];

endmodule

// File: rtl/sar_seq_ctrl.sv
// Session control: lock after reset, sample window, falling-edge counter.
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_hi,
  input  logic                 sclk_rise,
  input  logic                 sclk_fall,
  output logic                 adv,
  output logic                 load,
  output phase_e               ph,
  output logic [$clog2(W)-1:0] bidx,
  output logic                 oe,
  output logic                 track
);

  localparam int IW     = $clog2(W);
  localparam int CMAX_I = 2 * W + 2;
  localparam int CW     = $clog2(CMAX_I + 1);
  localparam logic [CW-1:0] C_NULL    = CW'(2);
  localparam logic [CW-1:0] C_MSB_END = CW'(W + 2);
  localparam logic [CW-1:0] C_LSB_END = CW'(2 * W + 1);
  localparam logic [CW-1:0] C_MAX     = CW'(CMAX_I);

  sess_e          sess_q, sess_d;
  logic           run_q, run_d;
  logic [CW-1:0]  cnt_q, cnt_d, cnt_inc;
  logic           oe_q, oe_d;
  logic           trk_q, trk_d;

  assign cnt_inc = (cnt_q == C_MAX) ? cnt_q : cnt_q + CW'(1);

  // next state
  always_comb begin
    sess_d = sess_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    oe_d   = oe_q;
    trk_d  = trk_q;
    adv    = 1'b0;
    case (sess_q)
      SESS_LOCK: begin
        if (cs_hi) sess_d = SESS_IDLE;
      end
      SESS_IDLE: begin
        if (!cs_hi) begin
          sess_d = SESS_RUN;
          run_d  = 1'b0;
          cnt_d  = '0;
        end
      end
      SESS_RUN: begin
        if (cs_hi) begin
          sess_d = SESS_IDLE;
          oe_d   = 1'b0;
          trk_d  = 1'b0;
          run_d  = 1'b0;
          cnt_d  = '0;
        end else begin
          if (sclk_rise && !run_q) begin
            run_d = 1'b1;
            trk_d = 1'b1;
          end
          if (sclk_fall) begin
            oe_d = 1'b1;
            if (run_q) begin
              adv   = 1'b1;
              cnt_d = cnt_inc;
              if (cnt_inc == C_NULL) trk_d = 1'b0;
            end
          end
        end
      end
      default: sess_d = SESS_LOCK;
    endcase
  end

  // phase and bit index of the edge being counted
  always_comb begin
    ph   = PH_PRE;
    bidx = '0;
    if (cnt_inc <= C_NULL) begin
      ph = PH_PRE;
    end else if (cnt_inc <= C_MSB_END) begin
      ph   = PH_MSB;
      bidx = IW'(C_MSB_END - cnt_inc);
    end else if (cnt_inc <= C_LSB_END) begin
      ph   = PH_LSB;
      bidx = IW'(cnt_inc - C_MSB_END);
    end else begin
      ph = PH_ZERO;
    end
  end

  assign load  = adv && (cnt_inc == C_NULL);
  assign oe    = oe_q;
  assign track = trk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q <= SESS_LOCK;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
      trk_q  <= 1'b0;
    end else begin
      sess_q <= sess_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      oe_q   <= oe_d;
      trk_q  <= trk_d;
    end
  end

endmodule

// File: rtl/sar_seq_core.sv
// Successive-approximation register: trial code and decided result.
module sar_seq_core
  import sar_seq_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 load,
  input  phase_e               ph,
  input  logic [$clog2(W)-1:0] bidx,
  input  logic                 comp_ge,
  output logic [W-1:0]         dac_code,
  output logic [W-1:0]         result
);

  localparam int IW = $clog2(W);

  logic [W-1:0] trial_q, trial_d;
  logic [W-1:0] res_q, res_d;
  logic         test_en;
  logic         upd_en;

  assign test_en = adv && (ph == PH_MSB);
  assign upd_en  = load || test_en;

  for (genvar g = 0; g < W; g++) begin : g_bit
    localparam bit TOP = (g == W - 1);
    logic hit;
    logic nxt;
    assign hit = test_en && (bidx == IW'(g));
    if (g < W - 1) begin : g_low
      assign nxt = test_en && (bidx == IW'(g + 1));
    end else begin : g_top
      assign nxt = 1'b0;
    end
    assign trial_d[g] = load ? TOP :
                        hit  ? comp_ge :
                        nxt  ? 1'b1 : trial_q[g];
    assign res_d[g]   = load ? 1'b0 :
                        hit  ? comp_ge : res_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      res_q   <= '0;
    end else if (upd_en) begin
      trial_q <= trial_d;
      res_q   <= res_d;
    end
  end

  assign dac_code = trial_q;
  assign result   = res_q;

endmodule

// File: rtl/sar_seq_shift.sv
// Serial data line register: null, MSB-first, LSB-first, then zeros.
module sar_seq_shift
  import sar_seq_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_hi,
  input  logic                 adv,
  input  phase_e               ph,
  input  logic [$clog2(W)-1:0] bidx,
  input  logic                 comp_ge,
  input  logic [W-1:0]         result,
  output logic                 sdo
);

  logic sdo_q, sdo_d;

  always_comb begin
    case (ph)
      PH_MSB:  sdo_d = comp_ge;
      PH_LSB:  sdo_d = result[bidx];
      default: sdo_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else if (cs_hi) begin
      sdo_q <= 1'b0;
    end else if (adv) begin
      sdo_q <= sdo_d;
    end
  end

  assign sdo = sdo_q;

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              comp_ge,
  output logic [CODE_W-1:0] dac_code,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              smp_track
);

  localparam int IW = $clog2(CODE_W);

  logic          cs_hi;
  logic          sclk_rise;
  logic          sclk_fall;
  logic          adv;
  logic          load;
  phase_e        ph;
  logic [IW-1:0] bidx;
  logic [CODE_W-1:0] result;

  sar_seq_edge #(.SYNC(SYNC_STAGES)) edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .cs_hi     (cs_hi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  sar_seq_ctrl #(.W(CODE_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_hi     (cs_hi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .adv       (adv),
    .load      (load),
    .ph        (ph),
    .bidx      (bidx),
    .oe        (sdo_oe),
    .track     (smp_track)
  );

  sar_seq_core #(.W(CODE_W)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load     (load),
    .ph       (ph),
    .bidx     (bidx),
    .comp_ge  (comp_ge),
    .dac_code (dac_code),
    .result   (result)
  );

  sar_seq_shift #(.W(CODE_W)) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_hi   (cs_hi),
    .adv     (adv),
    .ph      (ph),
    .bidx    (bidx),
    .comp_ge (comp_ge),
    .result  (result),
    .sdo     (sdo)
  );

endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_hi,
  input logic         sclk_rise,
  input logic         sclk_fall,
  input logic         adv,
  input logic         sdo,
  input logic         sdo_oe,
  input logic         smp_track,
  input logic [W-1:0] dac_code
);

  assert_oe_off_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_hi) |-> !sdo_oe);

  assert_oe_on_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> sdo_oe);

  assert_track_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_track) |-> $past(sclk_rise));

  assert_track_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smp_track) |-> ($past(sclk_fall) || $past(cs_hi)));

  assert_dac_on_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(adv));

  assert_sdo_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(sclk_fall) || $past(cs_hi)));

endmodule

bind sar_serial_seq sar_serial_seq_chk #(.W(CODE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_hi     (cs_hi),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .adv       (adv),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe),
  .smp_track (smp_track),
  .dac_code  (dac_code)
);

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb_top;

  localparam int W     = 12;
  localparam int HALF  = 4;
  localparam int NFULL = 2 * W + 4;
  localparam int NV    = 10;
  localparam int TV_VIN  [NV] = '{0, 4095, 2048, 2047, 1, 2730, 1365, 1234, 5000, -7};
  localparam int TV_EXP  [NV] = '{0, 4095, 2048, 2047, 1, 2730, 1365, 1234, 4095, 0};
  localparam int TV_IDLEH[NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n;
  logic         sclk;
  logic         comp_ge;
  logic [W-1:0] dac_code;
  logic         sdo;
  logic         sdo_oe;
  logic         smp_track;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int vin_live = 0;
  int vin_hold = 0;

  always #10 clk = ~clk;

  // analog model: track-and-hold plus comparator
  always_ff @(posedge clk) if (smp_track) vin_hold <= vin_live;
  always_comb comp_ge = (vin_hold >= int'(dac_code));

  sar_serial_seq #(.CODE_W(W), .SYNC_STAGES(1)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .comp_ge   (comp_ge),
    .dac_code  (dac_code),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .smp_track (smp_track)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one chip-select session; nfall counted falling edges, then cs_n rises
  task automatic run_conv(input int vin, input int expv, input bit idle_hi, input int nfall);
    logic [W-1:0] e;
    logic         prev;
    int           exb;
    e = W'(expv);
    prev = 1'b0;
    vin_live = vin;
    sclk = idle_hi;
    wait_n(3);
    cs_n = 1'b0;
    wait_n(HALF);
    chk("R3 oe before first fall", int'(sdo_oe), 0);
    if (idle_hi) begin
      sclk = 1'b0;
      wait_n(HALF);
      chk("R11 oe after leading fall", int'(sdo_oe), 1);
      chk("R11 leading fall not counted", int'(smp_track), 0);
    end
    for (int i = 1; i <= nfall; i++) begin
      sclk = 1'b1;
      wait_n(HALF);
      if (i == 1) chk("R4 track opens on first rise", int'(smp_track), 1);
      else        chk("R10 sdo stable across rise", int'(sdo), int'(prev));
      sclk = 1'b0;
      if (i == 3) begin
        wait_n(1);
        chk("R12 sdo unchanged one cycle after fall", int'(sdo), 0);
        wait_n(1);
        chk("R12 sdo updated two cycles after fall", int'(sdo), int'(e[W-1]));
        wait_n(HALF - 2);
      end else begin
        wait_n(HALF);
      end
      if (i <= 2)            exb = 0;
      else if (i <= W + 2)   exb = int'(e[W + 2 - i]);
      else if (i <= 2*W + 1) exb = int'(e[i - W - 2]);
      else                   exb = 0;
      if (i == 1) chk("R3 oe on first fall", int'(sdo_oe), 1);
      if (i == 2) begin
        chk("R5 null bit", int'(sdo), 0);
        chk("R4 track closes on second fall", int'(smp_track), 0);
        vin_live = 4095 - vin;
      end
      if (i >= 3 && i <= W + 2)        chk($sformatf("R7 msb-first edge %0d", i), int'(sdo), exb);
      else if (i > W + 2 && i <= 2*W+1) chk($sformatf("R8 lsb-first edge %0d", i), int'(sdo), exb);
      else if (i > 2*W + 1)             chk($sformatf("R9 zero edge %0d", i), int'(sdo), exb);
      prev = sdo;
    end
    if (nfall >= W + 2) chk("R6 final dac code", int'(dac_code), expv);
    cs_n = 1'b1;
    wait_n(HALF);
    chk("R3 oe off after cs high", int'(sdo_oe), 0);
    sclk = idle_hi;
    wait_n(HALF);
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b0;
    wait_n(3);
    chk("R1 oe in reset", int'(sdo_oe), 0);
    chk("R1 track in reset", int'(smp_track), 0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 sdo after reset", int'(sdo), 0);
    chk("R1 dac after reset", int'(dac_code), 0);
    chk("R1 oe after reset", int'(sdo_oe), 0);

    // vector table: full sessions in both clock idle levels
    for (int v = 0; v < NV; v++) run_conv(TV_VIN[v], TV_EXP[v], TV_IDLEH[v] != 0, NFULL);

    // R2: select low through reset release
    rst_n = 1'b0;
    cs_n  = 1'b0;
    sclk  = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    vin_live = 3000;
    wait_n(3);
    for (int k = 0; k < 6; k++) begin
      sclk = 1'b1; wait_n(HALF);
      chk("R2 track stays off while locked", int'(smp_track), 0);
      sclk = 1'b0; wait_n(HALF);
      chk("R2 oe stays off while locked", int'(sdo_oe), 0);
    end
    chk("R2 dac untouched while locked", int'(dac_code), 0);
    cs_n = 1'b1;
    wait_n(HALF);
    run_conv(3000, 3000, 1'b0, NFULL);

    // R3: abort mid conversion, then a fresh session
    run_conv(1000, 1000, 1'b0, 7);
    run_conv(100, 100, 1'b0, NFULL);
    run_conv(3500, 3500, 1'b1, W + 2);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule